// File: doc/BRIEF.md
# UART Framing Engine

This block turns bytes into a serial UART waveform and turns a received serial waveform back into bytes. A 16x oversampling tick from an external baud generator times both directions. The transmitter takes a character from a transmit queue through a valid/pop pair. It then shifts out a start bit, the data bits with the least significant bit first, an optional parity bit and one or two stop bits. The receiver watches the incoming line and resynchronises on every start bit. It samples each bit at its centre and hands each rebuilt character on with separate parity-error, framing-error and break flags.

The frame format is set by a handful of static configuration inputs. These cover the data length, stored as length minus one, parity on/off, parity sense and the number of stop bits. Two more inputs control the line itself. One holds the transmit line low as a forced break. The other makes new frames wait for a clear-to-send input. The queues, the configuration registers and the baud generator all sit outside the block. Each direction latches its format when a frame starts, so a format change only affects the next frame.

Top module: `uart_frame_engine`

## Requirements
- R1: The data length is `cfg_len_m1 + 1` bits (1 to 8). Transmit data bits above that length are ignored, and received data bits above it read as zero.
- R2: The transmit line idles high. A frame is a low start bit, then the data bits with bit 0 first, then the optional parity bit, then the stop bits. Each bit lasts 16 oversampling ticks.
- R3: With `cfg_par_en` set, a parity bit follows the data. With `cfg_par_even` = 1 the parity bit makes the count of ones across data plus parity even; with 0 it makes that count odd.
- R4: With `cfg_two_stop` = 1 the transmitter sends two high stop bits (32 ticks) before the next start bit; with 0 it sends one (16 ticks).
- R5: While `cfg_force_brk` is 1, `tx_line` is low whatever the transmitter is doing.
- R6: With `cfg_flow_en` = 1 no new frame starts while `cts` is 0. With `cfg_flow_en` = 0, `cts` has no effect.
- R7: `txq_pop` is a one-cycle pulse, given exactly once per transmitted frame, at the cycle the frame is launched from an available queue entry.
- R8: The receiver samples each bit at mid-bit. A start bit that is high again at its mid-point is dropped, and no character is reported.
- R9: Each received frame produces a single-cycle `rx_valid` pulse shortly after the first stop bit is sampled, with `rx_data` and the flags valid in that cycle.
- R10: `rx_par_err` is set when parity is enabled and the received parity bit does not match the configured sense.
- R11: `rx_frm_err` is set when the first stop bit is sampled low.
- R12: `rx_brk` is set when the stop bit is low and every data and parity bit was also low. After a low stop bit, the receiver waits for the line to go high before it accepts a new start bit, so a long break gives one report.
- R13: During and after reset, `tx_line` is high, `txq_pop` is 0 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_len_m1 | input | 3 | Data length minus one |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| cfg_flow_en | input | 1 | Gate new frames with `cts` |
| cfg_force_brk | input | 1 | Hold the transmit line low |
| cts | input | 1 | Clear to send, active high |
| txq_valid | input | 1 | Transmit queue holds a character |
| txq_data | input | 8 | Character at the head of the transmit queue |
| txq_pop | output | 1 | Consume the head of the transmit queue |
| tx_line | output | 1 | Serial transmit line |
| tx_busy | output | 1 | A frame is being transmitted |
| rx_line | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | Received character strobe |
| rx_data | output | 8 | Received character, zero above the length |
| rx_par_err | output | 1 | Parity mismatch for this character |
| rx_frm_err | output | 1 | First stop bit was low |
| rx_brk | output | 1 | Whole frame was low |

## Verification
On every cycle, the embedded properties check several rules. The pop pulse is always one cycle wide and is always followed by a low start bit. The line is high whenever the transmitter is idle or in a stop bit. The receive strobe is never two cycles long. A break always comes with a framing error. Reported data never has bits set above the configured length. The bench checks what only whole frames can show. It decodes the waveform at mid-bit against independently computed parity. It measures the spacing between start bits to tell one stop bit from two, and runs a loopback through the receiver. It also covers the clear-to-send stall, a glitch start, injected parity and framing faults, and a forced break seen by the receiver as a single break report.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned LEN_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_REARM
  } rx_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] len_m1;
    logic             par_en;
    logic             par_even;
    logic             two_stop;
  } frame_cfg_t;

  // Mask of the data bits that belong to a frame of len_m1+1 bits.
  function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len_m1);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i <= int'(len_m1));
    return m;
  endfunction

  // Parity bit to send or expect for the active data bits.
  function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                     input logic [LEN_W-1:0]  len_m1,
                                     input logic              even);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i <= int'(len_m1)) acc = acc ^ d[i];
    return even ? acc : ~acc;
  endfunction

endpackage

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_frame_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  frame_cfg_t        cfg,
  input  logic              force_brk,
  input  logic              flow_en,
  input  logic              cts,
  input  logic              txq_valid,
  input  logic [DATA_W-1:0] txq_data,
  output logic              txq_pop,
  output logic              tx_line,
  output logic              tx_busy
);
  localparam int unsigned CW = $clog2(OSR);

  tx_state_e         state;
  logic [CW-1:0]     tick_cnt;
  logic [LEN_W-1:0]  bit_idx;
  logic              stop_second;
  logic [DATA_W-1:0] shreg;
  frame_cfg_t        fcfg;
  logic              par_q;
  logic              line_q;

  // named events
  logic frame_launch;
  logic bit_end;

  assign frame_launch = (state == TX_IDLE) && txq_valid && (!flow_en || cts);
  assign bit_end      = os_tick && (tick_cnt == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= TX_IDLE;
      tick_cnt    <= '0;
      bit_idx     <= '0;
      stop_second <= 1'b0;
      shreg       <= '0;
      fcfg        <= '0;
      par_q       <= 1'b0;
      line_q      <= 1'b1;
    end else begin
      if (state == TX_IDLE || bit_end) tick_cnt <= '0;
      else if (os_tick)                tick_cnt <= tick_cnt + 1'b1;

      case (state)
        TX_IDLE: begin
          line_q <= 1'b1;
          if (frame_launch) begin
            state  <= TX_START;
            shreg  <= txq_data;
            fcfg   <= cfg;
            par_q  <= parity_of(txq_data, cfg.len_m1, cfg.par_even);
            line_q <= 1'b0;
          end
        end
        TX_START: if (bit_end) begin
          state   <= TX_DATA;
          bit_idx <= '0;
          line_q  <= shreg[0];
        end
        TX_DATA: if (bit_end) begin
          if (bit_idx == fcfg.len_m1) begin
            stop_second <= 1'b0;
            if (fcfg.par_en) begin
              state  <= TX_PAR;
              line_q <= par_q;
            end else begin
              state  <= TX_STOP;
              line_q <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
            shreg   <= shreg >> 1;
            line_q  <= shreg[1];
          end
        end
        TX_PAR: if (bit_end) begin
          state  <= TX_STOP;
          line_q <= 1'b1;
        end
        TX_STOP: if (bit_end) begin
          if (fcfg.two_stop && !stop_second) stop_second <= 1'b1;
          else                               state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign txq_pop = frame_launch;
  assign tx_line = force_brk ? 1'b0 : line_q;
  assign tx_busy = (state != TX_IDLE);

  AST_POP_THEN_START: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |=> (state == TX_START && line_q == 1'b0)); // R2
  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |=> !txq_pop); // R7
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !force_brk) |-> tx_line); // R2
  AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_STOP && !force_brk) |-> tx_line); // R4
  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && !cts) |-> !txq_pop); // R6

endmodule

// File: rtl/uart_rx_deserializer.sv
module uart_rx_deserializer
  import uart_frame_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              rx_line,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_brk
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned MID = OSR / 2 - 1;

  rx_state_e         state;
  logic              sync1, sync2;
  logic [CW-1:0]     tick_cnt;
  logic [LEN_W-1:0]  bit_idx;
  logic [DATA_W-1:0] data_q;
  logic [LEN_W-1:0]  len_q;
  logic              pen_q, peven_q;
  logic              par_seen;
  logic              any_one;

  // named events
  logic start_seen;
  logic mid_start;
  logic noise_drop;
  logic bit_sample;

  assign start_seen = (state == RX_IDLE) && os_tick && !sync2;
  assign mid_start  = (state == RX_START) && os_tick && (tick_cnt == CW'(MID));
  assign noise_drop = mid_start && sync2;
  assign bit_sample = os_tick && (tick_cnt == CW'(OSR - 1)) &&
                      (state == RX_DATA || state == RX_PAR || state == RX_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rx_line;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      tick_cnt   <= '0;
      bit_idx    <= '0;
      data_q     <= '0;
      len_q      <= '0;
      pen_q      <= 1'b0;
      peven_q    <= 1'b0;
      par_seen   <= 1'b0;
      any_one    <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      rx_brk     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (state == RX_IDLE || state == RX_REARM || mid_start || bit_sample)
        tick_cnt <= '0;
      else if (os_tick)
        tick_cnt <= tick_cnt + 1'b1;

      case (state)
        RX_IDLE: if (start_seen) begin
          state   <= RX_START;
          len_q   <= len_m1;
          pen_q   <= par_en;
          peven_q <= par_even;
        end
        RX_START: if (mid_start) begin
          if (noise_drop) state <= RX_IDLE;
          else begin
            state    <= RX_DATA;
            bit_idx  <= '0;
            data_q   <= '0;
            any_one  <= 1'b0;
            par_seen <= 1'b0;
          end
        end
        RX_DATA: if (bit_sample) begin
          data_q[bit_idx] <= sync2;
          any_one         <= any_one | sync2;
          if (bit_idx == len_q) state <= pen_q ? RX_PAR : RX_STOP;
          else                  bit_idx <= bit_idx + 1'b1;
        end
        RX_PAR: if (bit_sample) begin
          par_seen <= sync2;
          any_one  <= any_one | sync2;
          state    <= RX_STOP;
        end
        RX_STOP: if (bit_sample) begin
          rx_valid   <= 1'b1;
          rx_data    <= data_q;
          rx_par_err <= pen_q && (par_seen != parity_of(data_q, len_q, peven_q));
          rx_frm_err <= !sync2;
          rx_brk     <= !sync2 && !any_one;
          state      <= sync2 ? RX_IDLE : RX_REARM;
        end
        RX_REARM: if (sync2) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9
  AST_BRK_HAS_FE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> rx_frm_err); // R12
  AST_DATA_IN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data & ~len_mask(len_q)) == '0)); // R1
  AST_NOISE_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    noise_drop |=> !rx_valid); // R8
  AST_LOW_STOP_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_frm_err) |-> (state == RX_REARM || state == RX_IDLE)); // R11

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_frame_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic [2:0]  cfg_len_m1,
  input  logic        cfg_par_en,
  input  logic        cfg_par_even,
  input  logic        cfg_two_stop,
  input  logic        cfg_flow_en,
  input  logic        cfg_force_brk,
  input  logic        cts,
  input  logic        txq_valid,
  input  logic [7:0]  txq_data,
  output logic        txq_pop,
  output logic        tx_line,
  output logic        tx_busy,
  input  logic        rx_line,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  output logic        rx_par_err,
  output logic        rx_frm_err,
  output logic        rx_brk
);
  frame_cfg_t tx_cfg;

  assign tx_cfg.len_m1   = cfg_len_m1;
  assign tx_cfg.par_en   = cfg_par_en;
  assign tx_cfg.par_even = cfg_par_even;
  assign tx_cfg.two_stop = cfg_two_stop;

  uart_tx_serializer #(.OSR(OSR)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .cfg       (tx_cfg),
    .force_brk (cfg_force_brk),
    .flow_en   (cfg_flow_en),
    .cts       (cts),
    .txq_valid (txq_valid),
    .txq_data  (txq_data),
    .txq_pop   (txq_pop),
    .tx_line   (tx_line),
    .tx_busy   (tx_busy)
  );

  uart_rx_deserializer #(.OSR(OSR)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .len_m1     (cfg_len_m1),
    .par_en     (cfg_par_en),
    .par_even   (cfg_par_even),
    .rx_line    (rx_line),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err),
    .rx_brk     (rx_brk)
  );

endmodule

// File: tb/uart_frame_engine_tb.sv
module uart_frame_engine_tb_top;

  localparam int BIT_CLK = 64;   // 16 ticks x 4 clocks
  localparam int NVEC    = 8;
  // {len_m1[2:0], par_en, par_even, two_stop, data[7:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {3'd7, 1'b0, 1'b0, 1'b0, 8'hA5},
    {3'd7, 1'b1, 1'b1, 1'b0, 8'h3C},
    {3'd7, 1'b1, 1'b0, 1'b1, 8'hC3},
    {3'd4, 1'b0, 1'b0, 1'b0, 8'hFF},
    {3'd0, 1'b1, 1'b1, 1'b1, 8'h01},
    {3'd6, 1'b1, 1'b0, 1'b0, 8'h80},
    {3'd5, 1'b0, 1'b0, 1'b1, 8'h2D},
    {3'd7, 1'b1, 1'b1, 1'b1, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] tdiv = '0;
  always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
  logic os_tick;
  assign os_tick = (tdiv == 2'd3);

  logic [2:0] cfg_len_m1 = 3'd7;
  logic cfg_par_en = 0, cfg_par_even = 0, cfg_two_stop = 0;
  logic cfg_flow_en = 0, cfg_force_brk = 0, cts = 0;
  logic [7:0] txq_data = '0;
  logic txq_pop, tx_line, tx_busy, txq_valid;
  logic rx_valid, rx_par_err, rx_frm_err, rx_brk;
  logic [7:0] rx_data;
  logic loop_en = 1'b1, bench_rx = 1'b1;
  logic rx_line;
  assign rx_line = loop_en ? tx_line : bench_rx;

  int pop_cnt = 0, pop_target = 0;
  assign txq_valid = (pop_cnt != pop_target);
  always_ff @(posedge clk) if (txq_pop) pop_cnt <= pop_cnt + 1;

  int rx_cnt = 0;
  logic [7:0] cap_data = '0;
  logic cap_pe = 0, cap_fe = 0, cap_brk = 0;
  always_ff @(posedge clk) if (rx_valid) begin
    rx_cnt   <= rx_cnt + 1;
    cap_data <= rx_data;
    cap_pe   <= rx_par_err;
    cap_fe   <= rx_frm_err;
    cap_brk  <= rx_brk;
  end

  uart_frame_engine dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .cfg_len_m1(cfg_len_m1), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_two_stop(cfg_two_stop), .cfg_flow_en(cfg_flow_en), .cfg_force_brk(cfg_force_brk),
    .cts(cts), .txq_valid(txq_valid), .txq_data(txq_data), .txq_pop(txq_pop),
    .tx_line(tx_line), .tx_busy(tx_busy), .rx_line(rx_line), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  always_ff @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Wait for a high-to-low transition on tx_line; returns the cycle count.
  task automatic wait_tx_fall(output int t, input string req);
    logic prev;
    int   lim;
    prev = tx_line;
    lim  = 0;
    t    = -1;
    while (lim < 4000) begin
      @(negedge clk);
      if (prev && !tx_line) begin
        t = cyc;
        break;
      end
      prev = tx_line;
      lim++;
    end
    if (t < 0) check(1'b0, req, 0, 1);
  endtask

  task automatic drive_rx_bit(input logic b);
    bench_rx = b;
    wait_clk(BIT_CLK);
  endtask

  task automatic send_rx(input logic [7:0] d, input int nbits, input logic with_par,
                         input logic par_bit, input logic stop_bit);
    drive_rx_bit(1'b0);
    for (int i = 0; i < nbits; i++) drive_rx_bit(d[i]);
    if (with_par) drive_rx_bit(par_bit);
    drive_rx_bit(stop_bit);
    bench_rx = 1'b1;
    wait_clk(3 * BIT_CLK);
  endtask

  logic done = 1'b0;

  initial begin
    // ---------------- reset state (R13)
    wait_clk(3);
    check(tx_line === 1'b1, "R13 tx_line in reset", int'(tx_line), 1);
    check(txq_pop === 1'b0, "R13 pop in reset", int'(txq_pop), 0);
    check(rx_valid === 1'b0, "R13 rx_valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    wait_clk(20);
    check(tx_line === 1'b1 && rx_cnt == 0, "R13 idle after reset", int'(tx_line), 1);

    // ---------------- vector table, loopback, cts low and ignored (R6)
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] len;
      logic pe, pev, two;
      logic [7:0] d, m;
      logic pbit;
      int nb, nbits, t0, t1, p0, r0;
      {len, pe, pev, two, d} = VEC[v];
      nb    = int'(len) + 1;
      m     = 8'hFF >> (7 - len);
      pbit  = pev ? ($countones(d & m) % 2 == 1) : ($countones(d & m) % 2 == 0);
      nbits = 1 + nb + (pe ? 1 : 0) + (two ? 2 : 1);
      cfg_len_m1 = len; cfg_par_en = pe; cfg_par_even = pev; cfg_two_stop = two;
      txq_data = d;
      p0 = pop_cnt; r0 = rx_cnt;
      pop_target = pop_cnt + 2;
      wait_tx_fall(t0, "R2 no start bit");
      wait_clk(30);
      check(tx_line == 1'b0, "R2 start bit low", int'(tx_line), 0);
      for (int k = 0; k < nb; k++) begin
        wait_clk(BIT_CLK);
        check(tx_line == d[k], "R1 data bit lsb first", int'(tx_line), int'(d[k]));
      end
      if (pe) begin
        wait_clk(BIT_CLK);
        check(tx_line == pbit, "R3 parity bit", int'(tx_line), int'(pbit));
      end
      for (int s = 0; s < (two ? 2 : 1); s++) begin
        wait_clk(BIT_CLK);
        check(tx_line == 1'b1, "R4 stop bit high", int'(tx_line), 1);
      end
      wait_tx_fall(t1, "R4 second frame missing");
      check((t1 - t0) >= BIT_CLK * nbits - 3 && (t1 - t0) <= BIT_CLK * nbits + 3,
            "R4 frame spacing", t1 - t0, BIT_CLK * nbits);
      wait_clk(BIT_CLK * nbits + 200);
      check(pop_cnt - p0 == 2, "R7 one pop per frame", pop_cnt - p0, 2);
      check(rx_cnt - r0 == 2, "R9 one strobe per frame", rx_cnt - r0, 2);
      check(cap_data == (d & m), "R1 received data masked", int'(cap_data), int'(d & m));
      check({cap_pe, cap_fe, cap_brk} == 3'b000, "R10 R11 R12 clean flags",
            int'({cap_pe, cap_fe, cap_brk}), 0);
    end

    // ---------------- handshake stall (R6)
    begin
      int p0, t;
      cfg_len_m1 = 3'd7; cfg_par_en = 0; cfg_two_stop = 0;
      cfg_flow_en = 1; cts = 0; txq_data = 8'h55;
      p0 = pop_cnt;
      pop_target = pop_cnt + 1;
      wait_clk(600);
      check(pop_cnt == p0, "R6 no pop while cts low", pop_cnt - p0, 0);
      check(tx_line == 1'b1, "R6 line idle while stalled", int'(tx_line), 1);
      cts = 1;
      wait_tx_fall(t, "R6 frame after cts");
      check(pop_cnt == p0 + 1, "R6 pop after cts", pop_cnt - p0, 1);
      wait_clk(BIT_CLK * 12);
      cfg_flow_en = 0; cts = 0;
    end

    // ---------------- forced break on tx and break detect on loopback (R5, R12)
    begin
      int r0;
      r0 = rx_cnt;
      cfg_force_brk = 1;
      for (int i = 0; i < 4; i++) begin
        wait_clk(200);
        check(tx_line == 1'b0, "R5 forced low", int'(tx_line), 0);
      end
      wait_clk(BIT_CLK * 14);
      cfg_force_brk = 0;
      wait_clk(5);
      check(tx_line == 1'b1, "R5 released high", int'(tx_line), 1);
      wait_clk(300);
      check(rx_cnt - r0 == 1, "R12 single break report", rx_cnt - r0, 1);
      check(cap_brk == 1'b1 && cap_fe == 1'b1, "R12 break flags",
            int'({cap_brk, cap_fe}), 3);
      check(cap_data == 8'h00, "R12 break data", int'(cap_data), 0);
    end

    // ---------------- receiver directed cases
    loop_en = 1'b0;
    bench_rx = 1'b1;
    wait_clk(100);
    begin
      int r0;
      // glitch start (R8)
      r0 = rx_cnt;
      bench_rx = 1'b0;
      wait_clk(16);
      bench_rx = 1'b1;
      wait_clk(BIT_CLK * 12);
      check(rx_cnt == r0, "R8 glitch rejected", rx_cnt - r0, 0);

      // parity error, even sense (R10): 0x5A has 4 ones, correct bit 0, send 1
      cfg_len_m1 = 3'd7; cfg_par_en = 1; cfg_par_even = 1;
      r0 = rx_cnt;
      send_rx(8'h5A, 8, 1'b1, 1'b1, 1'b1);
      check(rx_cnt - r0 == 1, "R9 strobe on bad parity frame", rx_cnt - r0, 1);
      check(cap_pe == 1'b1 && cap_fe == 1'b0, "R10 parity error flagged",
            int'({cap_pe, cap_fe}), 2);
      check(cap_data == 8'h5A, "R10 data kept", int'(cap_data), 8'h5A);

      // correct odd parity: 0x5B has 5 ones, odd sense bit 0
      cfg_par_even = 0;
      send_rx(8'h5B, 8, 1'b1, 1'b0, 1'b1);
      check(cap_pe == 1'b0, "R10 good odd parity", int'(cap_pe), 0);

      // framing error (R11)
      cfg_par_en = 0;
      r0 = rx_cnt;
      send_rx(8'h81, 8, 1'b0, 1'b0, 1'b0);
      check(rx_cnt - r0 == 1 && cap_fe == 1'b1 && cap_brk == 1'b0,
            "R11 framing error without break", int'({cap_fe, cap_brk}), 2);
      check(cap_data == 8'h81, "R11 data kept", int'(cap_data), 8'h81);

      // short length from the bench side (R1)
      cfg_len_m1 = 3'd4;
      send_rx(8'h16, 5, 1'b0, 1'b0, 1'b1);
      check(cap_data == 8'h16 && cap_fe == 1'b0, "R1 five-bit receive",
            int'(cap_data), 8'h16);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule